// File: doc/BRIEF.md
# Dual-Clock Watchdog Timer

This block is a memory-mapped watchdog. It has two clock domains. The register port runs on a peripheral clock. The countdown runs on a slower oscillator clock.

Software programs a 12-bit period and sets the enable bit. It then keeps the system alive by pinging, which means writing 1 to the clear register. If no ping arrives, the first full period raises an interrupt. If the next full period also passes with no ping, the block raises a reset request. A parity-error input from the processor can raise the same reset request at any time. The reset request stays high until the block itself is reset.

Every setting and command written on the peripheral side crosses to the oscillator side through a request/acknowledge handshake. A multi-bit setting is therefore never sampled while it is changing. Read-back of the control and period registers shows a new value only after its handshake completes. Until then it returns the previous value. The prescaler depth is a parameter. In the target system it is 2^20, so one period equals 1024·1024·(N+1) oscillator cycles.

Top module: `wdog_dualclk`

## Requirements
- R1: After reset, all four registers read 0, and `irq_o` and `rst_req_o` are low.
- R2: Bit 0 of the control register (word offset 0x00) enables counting, and its other bits read 0. A write shows in read-back only after the handshake completes. A read on the cycle after the write still returns the old value.
- R3: The period register (offset 0x04) keeps only bits 31:20 as the period N. All other bits read 0.
- R4: With counting enabled from a zero count, `irq_o` rises 2^PRESC_LOG2·(N+1) oscillator cycles after counting starts.
- R5: If no ping arrives, `rst_req_o` rises exactly 2^PRESC_LOG2·(N+1) oscillator cycles after `irq_o` rose.
- R6: Writing a word with bit 0 set to offset 0x0C is a ping. It clears the count and the pending interrupt. Writing 0 there has no effect. Regular pings keep `irq_o` low.
- R7: Writing the value 0 to offset 0x08 restarts the count without clearing a pending interrupt. Reads of 0x08 return 0.
- R8: Bit 0 of offset 0x0C reads back the pending-interrupt flag.
- R9: `parity_err`, high on an oscillator edge, sets `rst_req_o` on that edge, whether or not counting is enabled.
- R10: Once set, `rst_req_o` stays high until `rst`.
- R11: With the enable bit clear, the count holds and no interrupt or reset request arises from timeout.
- R12: Writes made while a transfer is in flight are merged. The latest setting values and all pending commands reach the oscillator side in a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Peripheral (register) clock |
| oclk | input | 1 | Oscillator (count) clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| bus_we | input | 1 | Write strobe for one pclk cycle |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| parity_err | input | 1 | Processor parity error, synchronous to oclk |
| irq_o | output | 1 | Pending interrupt after the first overflow (oclk domain) |
| rst_req_o | output | 1 | Sticky reset request (oclk domain) |

## Verification
The assertions assume the following about the inputs:
- `rst` is held for several edges of both clocks.
- `parity_err` already belongs to the oscillator domain.
- Bus writes are single-cycle strobes whose address bits 3:2 are meaningful.

The stimulus meets these conditions. It drives every pclk input on falling edges and pulses `parity_err` on a falling oscillator edge. It holds reset for many cycles of the slower clock. It spaces pings and restarts well inside one period, so the outcome never depends on where the handshake latency falls. Timing windows that involve that latency are checked as ranges. Intervals entirely on the oscillator side are checked exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W   = 32;
    localparam int PERIOD_W = 12;
    localparam int PER_LSB  = DATA_W - PERIOD_W;

    // word index = bus_addr[3:2]
    localparam logic [1:0] IDX_CTRL  = 2'd0;
    localparam logic [1:0] IDX_PER   = 2'd1;
    localparam logic [1:0] IDX_ELAP  = 2'd2;
    localparam logic [1:0] IDX_CLR   = 2'd3;

    // one bundle of settings and commands carried across the handshake
    typedef struct packed {
        logic                en;
        logic [PERIOD_W-1:0] per;
        logic                ping;
        logic                restart;
    } wd_cfg_t;

    function automatic logic [DATA_W-1:0] per_word(input logic [PERIOD_W-1:0] p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1:PER_LSB] = p;
        return w;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              pclk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_s,
    input  logic              ack_s,
    output logic              req_o,
    output wd_cfg_t           xfer_o,
    output logic              vis_en_o,
    output logic              busy_o
);
    wd_cfg_t             stage;
    wd_cfg_t             xfer;
    logic                dirty;
    logic                busy;
    logic                req;
    logic                ack_d;
    logic                vis_en;
    logic [PERIOD_W-1:0] vis_per;
    logic [1:0]          idx;
    logic                ack_edge;

    assign idx      = bus_addr[3:2];
    assign ack_edge = ack_s ^ ack_d;

    always_ff @(posedge pclk) begin
        if (rst) begin
            stage   <= '0;
            xfer    <= '0;
            dirty   <= 1'b0;
            busy    <= 1'b0;
            req     <= 1'b0;
            ack_d   <= 1'b0;
            vis_en  <= 1'b0;
            vis_per <= '0;
        end else begin
            ack_d <= ack_s;
            // launch a transfer of the staged bundle when idle
            if (!busy && dirty) begin
                xfer          <= stage;
                req           <= ~req;
                busy          <= 1'b1;
                dirty         <= 1'b0;
                stage.ping    <= 1'b0;
                stage.restart <= 1'b0;
            end
            if (busy && ack_edge) begin
                busy    <= 1'b0;
                vis_en  <= xfer.en;
                vis_per <= xfer.per;
            end
            // writes land after the launch so they win over its clears
            if (bus_we) begin
                unique case (idx)
                    IDX_CTRL: begin
                        stage.en <= bus_wdata[0];
                        dirty    <= 1'b1;
                    end
                    IDX_PER: begin
                        stage.per <= bus_wdata[DATA_W-1:PER_LSB];
                        dirty     <= 1'b1;
                    end
                    IDX_ELAP: begin
                        if (bus_wdata == '0) begin
                            stage.restart <= 1'b1;
                            dirty         <= 1'b1;
                        end
                    end
                    IDX_CLR: begin
                        if (bus_wdata[0]) begin
                            stage.ping <= 1'b1;
                            dirty      <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_CTRL: bus_rdata[0] = vis_en;
            IDX_PER:  bus_rdata    = per_word(vis_per);
            IDX_ELAP: bus_rdata    = '0;
            IDX_CLR:  bus_rdata[0] = irq_s;
        endcase
    end

    assign req_o    = req;
    assign xfer_o   = xfer;
    assign vis_en_o = vis_en;
    assign busy_o   = busy;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int PRESC_LOG2 = 20
) (
    input  logic    oclk,
    input  logic    rst,
    input  logic    req_s,
    input  wd_cfg_t xfer,
    input  logic    parity_err,
    output logic    ack_o,
    output logic    irq_o,
    output logic    rst_req_o
);
    logic                  req_d;
    logic                  ack;
    logic                  run_en;
    logic [PERIOD_W-1:0]   run_per;
    logic [PRESC_LOG2-1:0] pre;
    logic [PERIOD_W-1:0]   unit;
    logic                  irq;
    logic                  rreq;
    logic                  load;
    logic                  clr_cnt;
    logic                  ovf;

    assign load    = req_s ^ req_d;
    assign clr_cnt = load && (xfer.ping || xfer.restart);
    assign ovf     = run_en && (&pre) && (unit >= run_per) && !clr_cnt;

    always_ff @(posedge oclk) begin
        if (rst) begin
            req_d   <= 1'b0;
            ack     <= 1'b0;
            run_en  <= 1'b0;
            run_per <= '0;
            pre     <= '0;
            unit    <= '0;
            irq     <= 1'b0;
            rreq    <= 1'b0;
        end else begin
            req_d <= req_s;
            if (load) begin
                ack     <= req_s;
                run_en  <= xfer.en;
                run_per <= xfer.per;
            end
            if (clr_cnt) begin
                pre  <= '0;
                unit <= '0;
            end else if (run_en) begin
                pre <= pre + 1'b1;
                if (&pre) unit <= (unit >= run_per) ? '0 : unit + 1'b1;
            end
            if (load && xfer.ping) irq <= 1'b0;
            else if (ovf)          irq <= 1'b1;
            if (parity_err || (ovf && irq)) rreq <= 1'b1;
        end
    end

    assign ack_o     = ack;
    assign irq_o     = irq;
    assign rst_req_o = rreq;
endmodule

// File: rtl/wdog_dualclk.sv
module wdog_dualclk
    import wdog_pkg::*;
#(
    parameter int PRESC_LOG2  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic        pclk,
    input  logic        oclk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        parity_err,
    output logic        irq_o,
    output logic        rst_req_o
);
    wd_cfg_t xfer;
    logic    req_p, req_s;
    logic    ack_o2p, ack_s;
    logic    irq_s;
    logic    vis_en;
    logic    xfer_busy;

    wdog_regs u_regs (
        .pclk      (pclk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_s     (irq_s),
        .ack_s     (ack_s),
        .req_o     (req_p),
        .xfer_o    (xfer),
        .vis_en_o  (vis_en),
        .busy_o    (xfer_busy)
    );

    wdog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (oclk), .rst (rst), .d (req_p), .q (req_s)
    );

    wdog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (pclk), .rst (rst), .d (ack_o2p), .q (ack_s)
    );

    wdog_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
        .clk (pclk), .rst (rst), .d (irq_o), .q (irq_s)
    );

    wdog_core #(.PRESC_LOG2(PRESC_LOG2)) u_core (
        .oclk       (oclk),
        .rst        (rst),
        .req_s      (req_s),
        .xfer       (xfer),
        .parity_err (parity_err),
        .ack_o      (ack_o2p),
        .irq_o      (irq_o),
        .rst_req_o  (rst_req_o)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic       pclk,
    input logic       oclk,
    input logic       rst,
    input logic       bus_we,
    input logic [3:0] bus_addr,
    input logic       parity_err,
    input logic       irq_o,
    input logic       rst_req_o,
    input logic       vis_en,
    input logic       xfer_busy
);
    // R10
    sticky_rst_chk: assert property (@(posedge oclk) disable iff (rst)
        rst_req_o |=> rst_req_o);

    // R9
    parity_rst_chk: assert property (@(posedge oclk) disable iff (rst)
        parity_err |=> rst_req_o);

    // R5
    second_ovf_chk: assert property (@(posedge oclk) disable iff (rst)
        $rose(rst_req_o) |-> ($past(irq_o) || $past(parity_err)));

    // R2
    late_readback_chk: assert property (@(posedge pclk) disable iff (rst)
        (bus_we && bus_addr[3:2] == 2'd0 && !xfer_busy) |=> $stable(vis_en));

    // R6
    irq_needs_sync_chk: assert property (@(posedge oclk) disable iff (rst)
        $fell(irq_o) |-> !rst_req_o || $past(rst_req_o));
endmodule

bind wdog_dualclk wdog_chk u_chk (
    .pclk       (pclk),
    .oclk       (oclk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .parity_err (parity_err),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o),
    .vis_en     (vis_en),
    .xfer_busy  (xfer_busy)
);

// File: tb/sim_wdog_dualclk.sv
`timescale 1ns/1ps
module sim_wdog_dualclk;
    localparam int PL = 3;

    logic        pclk = 0, oclk = 0, rst = 1;
    logic        bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        parity_err = 0;
    logic        irq_o, rst_req_o;

    int checks = 0, failures = 0;
    int ocyc = 0;
    int irq_at = -1, rst_at = -1;
    bit irq_seen = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb[$];
    event mon_ev;

    always #4  pclk = ~pclk;   // 125 MHz
    always #10 oclk = ~oclk;

    wdog_dualclk #(.PRESC_LOG2(PL)) u0 (
        .pclk(pclk), .oclk(oclk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .parity_err(parity_err),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always @(posedge oclk) ocyc <= ocyc + 1;

    always @(negedge oclk) begin
        if (irq_o) begin
            irq_seen = 1;
            if (irq_at < 0) irq_at = ocyc;
        end
        if (rst_req_o && rst_at < 0) rst_at = ocyc;
    end

    // monitor: pops expected read values and compares
    initial begin
        forever begin
            exp_t it;
            @(mon_ev);
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s: read got %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge pclk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge pclk);
        bus_addr = a;
        sb.push_back('{e, tag});
        #2;
        -> mon_ev;
        #1;
    endtask

    task automatic pwait(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic do_reset;
        rst = 1;
        pwait(20);
        rst = 0;
        irq_at = -1; rst_at = -1; irq_seen = 0;
        pwait(2);
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim && irq_at < 0; i++) @(negedge oclk);
    endtask

    initial begin
        int P, t0;
        P = (1 << PL) * 3;  // N = 2
        do_reset();
        // R1 reset state
        rd(4'h0, 32'h0, "R1 ctrl");
        rd(4'h4, 32'h0, "R1 period");
        rd(4'h8, 32'h0, "R1 elapsed");
        rd(4'hC, 32'h0, "R1 clear");
        chk(!irq_o && !rst_req_o, "R1 outputs", {irq_o, rst_req_o}, 0);

        // R3 field masking, R2 late read-back
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, 32'h0, "R2 period old value");
        pwait(30);
        rd(4'h4, 32'hFFF0_0000, "R3 period mask");
        wr(4'h4, 32'h0020_1234);
        pwait(30);
        rd(4'h4, 32'h0020_0000, "R3 period N=2");

        // R4 first overflow timing
        wr(4'h0, 32'hFFFF_FFFF);
        t0 = ocyc;
        rd(4'h0, 32'h0, "R2 ctrl old value");
        wait_irq(200);
        chk(irq_at >= t0 + P - 2 && irq_at <= t0 + P + 8, "R4 irq timing", irq_at - t0, P);
        pwait(6);
        rd(4'h0, 32'h1, "R2 ctrl enable");
        rd(4'hC, 32'h1, "R8 irq flag");
        rd(4'h8, 32'h0, "R7 elapsed reads 0");
        // R5 second overflow
        for (int i = 0; i < 300 && rst_at < 0; i++) @(negedge oclk);
        chk(rst_at - irq_at == P, "R5 second overflow", rst_at - irq_at, P);
        pwait(100);
        chk(rst_req_o == 1, "R10 sticky", rst_req_o, 1);

        do_reset();
        chk(rst_req_o == 0, "R10 cleared by reset", rst_req_o, 0);

        // R6 regular pings keep irq low
        wr(4'h4, 32'h0020_0000);
        wr(4'h0, 32'h1);
        for (int i = 0; i < 10; i++) begin
            pwait(13);
            wr(4'hC, 32'h1);
        end
        chk(!irq_seen, "R6 pings hold off irq", irq_seen, 0);
        // R7 restarts also hold off irq
        for (int i = 0; i < 10; i++) begin
            pwait(13);
            wr(4'h8, 32'h0);
        end
        chk(!irq_seen, "R7 restart holds off irq", irq_seen, 0);
        wait_irq(200);
        chk(irq_at >= 0, "R4 irq after pings stop", irq_at, 1);
        // R7 restart does not clear pending irq
        wr(4'h8, 32'h0);
        pwait(12);
        chk(irq_o == 1, "R7 irq kept by restart", irq_o, 1);
        // R6 writing 0 to clear has no effect
        wr(4'hC, 32'h0);
        pwait(10);
        chk(irq_o == 1, "R6 zero write no effect", irq_o, 1);
        wr(4'hC, 32'h1);
        pwait(14);
        chk(irq_o == 0 && rst_req_o == 0, "R6 ping clears irq", irq_o, 0);
        rd(4'hC, 32'h0, "R8 flag cleared");

        // R12 merged writes, R11 disable
        wr(4'hC, 32'h1);
        wr(4'h4, 32'h0030_0000);
        wr(4'h0, 32'h0);
        pwait(40);
        rd(4'h0, 32'h0, "R12 ctrl merged");
        rd(4'h4, 32'h0030_0000, "R12 period merged");
        irq_seen = 0;
        pwait(300);
        chk(!irq_seen && !rst_req_o, "R11 disabled holds", irq_seen, 0);

        // R9 parity error
        @(negedge oclk); parity_err = 1;
        @(negedge oclk); parity_err = 0;
        chk(rst_req_o == 1, "R9 parity reset", rst_req_o, 1);
        pwait(40);
        chk(rst_req_o == 1, "R10 sticky after parity", rst_req_o, 1);

        pwait(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge pclk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run hung got 0 expected 1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule